// File: doc/BRIEF.md
# Two-Master Bus Arbiter

This block arbitrates a shared bus between two masters. Each master drives an active-low request line and receives an active-low grant line. The arbiter also watches three shared active-low bus lines: transfer start (`ts_n`), bus busy (`bb_n`) and tenure end (`btt_n`). From these it tracks whether a bus tenure is in progress.

A tenure begins with a transfer start. It ends when tenure end is asserted, or when bus busy goes from low to high. The grant moves to the other master whenever that master asks and the current owner is either not requesting or not inside a tenure. The arbiter never waits for the granted master to run a cycle: a master that holds the grant without a transfer start can lose it on the next edge.

A handover always passes through a gap of `GAP_CYCLES` clocks with no grant asserted, so the grant never goes straight from one master to the other. While reset is low, the grant rests on a single fixed master. When nobody requests, the grant stays parked on the last owner.

Top module: `arb2_bus_arbiter`

## Requirements
- R1: While `rst_n` is low, `gnt_n` holds the parking value: 2'b10 (master 0 granted) for the default `PARK_MASTER` of 0. `tenure_active` reads 0.
- R2: `gnt_n` is never 2'b00. Between a grant to one master and a grant to the other there is at least one clock with `gnt_n` equal to 2'b11.
- R3: Take an edge at which the owner's request is high and the other master's request is low. After that edge `gnt_n` is 2'b11. With the default `GAP_CYCLES` of 1, the edge after that grants the requester.
- R4: The owner may still be requesting. If at the sampling edge `tenure_active` is 0 and `ts_n` is high, a request from the other master still starts a handover. No bus cycle from the owner is awaited.
- R5: Take an owner that is requesting while a tenure is in progress (`tenure_active` is 1 or `ts_n` is low at the edge). That owner keeps its grant even if the other master requests.
- R6: An edge that samples `ts_n` low, with `btt_n` high and no rising `bb_n`, sets `tenure_active` after that edge.
- R7: An edge that samples `btt_n` low clears `tenure_active` after that edge, even when `ts_n` is low at the same edge.
- R8: An edge that samples `bb_n` high, when it was low at the previous edge, clears `tenure_active`.
- R9: With both requests high, the grant stays on the last owner indefinitely.
- R10: Once a handover gap has begun, it completes to its target even if that target drops its request during the gap.
- R11: When both masters request continuously and no tenure is started, the grant alternates between the two masters, with the gap between each grant.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 2 | Active-low request, bit i from master i |
| ts_n | input | 1 | Shared active-low transfer start |
| bb_n | input | 1 | Shared active-low bus busy |
| btt_n | input | 1 | Shared active-low tenure end |
| gnt_n | output | 2 | Registered active-low grant, bit i to master i |
| tenure_active | output | 1 | Registered flag, high while a bus tenure is in progress |

## Verification
The checker assumes that `bb_n` is high while reset is applied. Its bus-busy edge check compares against the value from the previous clock, so it needs the same starting point as the design's internal history. It also assumes that all inputs are stable around each rising edge. The stimulus drives every input on the falling edge and keeps `bb_n`, `ts_n` and `btt_n` high throughout reset. The gap-completion property is only enabled for a single-cycle gap, which is the configuration the directed scenarios exercise.

// File: rtl/arb2_pkg.sv
package arb2_pkg;

    typedef enum logic {
        ST_OWN = 1'b0,
        ST_GAP = 1'b1
    } gstate_e;

    typedef struct packed {
        gstate_e    st;
        logic       owner;
        logic [1:0] gnt_n;
    } gctl_s;

    typedef struct packed {
        logic active;
        logic bb_prev;
    } ten_s;

    // active-low grant vector selecting one master
    function automatic logic [1:0] grant_vec_n(input logic m);
        return m ? 2'b01 : 2'b10;
    endfunction

endpackage

// File: rtl/arb2_tenure_track.sv
module arb2_tenure_track
    import arb2_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ts_n,
    input  logic bb_n,
    input  logic btt_n,
    output logic busy,
    output logic active
);

    ten_s ten_d, ten_q;

    always_comb begin
        ten_d         = ten_q;
        ten_d.bb_prev = bb_n;
        // end of tenure takes priority over a new start in the same cycle
        if (!btt_n || (!ten_q.bb_prev && bb_n)) begin
            ten_d.active = 1'b0;
        end else if (!ts_n) begin
            ten_d.active = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ten_q <= '{active: 1'b0, bb_prev: 1'b1};
        end else begin
            ten_q <= ten_d;
        end
    end

    // a start seen this cycle already counts as an open tenure
    assign busy   = ten_q.active | ~ts_n;
    assign active = ten_q.active;

endmodule

// File: rtl/arb2_grant_ctrl.sv
module arb2_grant_ctrl
    import arb2_pkg::*;
#(
    parameter bit PARK_MASTER = 1'b0,
    parameter int GAP_CYCLES  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_n,
    input  logic       busy,
    output logic [1:0] gnt_n
);

    localparam int             CW       = (GAP_CYCLES > 1) ? $clog2(GAP_CYCLES) : 1;
    localparam logic [CW-1:0]  GAP_LOAD = CW'(GAP_CYCLES - 1);
    localparam gctl_s          CTL_RST  = '{st: ST_OWN, owner: PARK_MASTER,
                                           gnt_n: grant_vec_n(PARK_MASTER)};

    gctl_s         ctl_d, ctl_q;
    logic [CW-1:0] cnt_d, cnt_q;
    logic          cur, oth, own_wants, oth_wants;

    always_comb begin
        ctl_d     = ctl_q;
        cnt_d     = cnt_q;
        cur       = ctl_q.owner;
        oth       = ~ctl_q.owner;
        own_wants = ~req_n[cur];
        oth_wants = ~req_n[oth];
        unique case (ctl_q.st)
            ST_OWN: begin
                if (oth_wants && (!own_wants || !busy)) begin
                    ctl_d.st    = ST_GAP;
                    ctl_d.owner = oth;
                    ctl_d.gnt_n = 2'b11;
                    cnt_d       = GAP_LOAD;
                end
            end
            ST_GAP: begin
                if (cnt_q == '0) begin
                    ctl_d.st    = ST_OWN;
                    ctl_d.gnt_n = grant_vec_n(ctl_q.owner);
                end else begin
                    cnt_d = cnt_q - 1'b1;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
            cnt_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            cnt_q <= cnt_d;
        end
    end

    assign gnt_n = ctl_q.gnt_n;

endmodule

// File: rtl/arb2_bus_arbiter.sv
module arb2_bus_arbiter #(
    parameter bit PARK_MASTER = 1'b0,
    parameter int GAP_CYCLES  = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_n,
    input  logic       ts_n,
    input  logic       bb_n,
    input  logic       btt_n,
    output logic [1:0] gnt_n,
    output logic       tenure_active
);

    logic busy;

    arb2_tenure_track u_tenure (
        .clk    (clk),
        .rst_n  (rst_n),
        .ts_n   (ts_n),
        .bb_n   (bb_n),
        .btt_n  (btt_n),
        .busy   (busy),
        .active (tenure_active)
    );

    arb2_grant_ctrl #(
        .PARK_MASTER (PARK_MASTER),
        .GAP_CYCLES  (GAP_CYCLES)
    ) u_grant (
        .clk   (clk),
        .rst_n (rst_n),
        .req_n (req_n),
        .busy  (busy),
        .gnt_n (gnt_n)
    );

endmodule

// File: rtl/arb2_bus_arbiter_chk.sv
module arb2_bus_arbiter_chk #(
    parameter bit PARK_MASTER = 1'b0,
    parameter int GAP_CYCLES  = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] req_n,
    input logic       ts_n,
    input logic       bb_n,
    input logic       btt_n,
    input logic [1:0] gnt_n,
    input logic       tenure_active
);

    localparam logic [1:0] PARK_N = PARK_MASTER ? 2'b01 : 2'b10;

    // R1
    reset_park_chk: assert property (@(posedge clk)
        !rst_n |=> (gnt_n == PARK_N));

    // R2
    no_dual_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gnt_n != 2'b00);

    // R2
    m0_no_direct_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_n[0] |=> gnt_n[1]);

    // R2
    m1_no_direct_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gnt_n[1] |=> gnt_n[0]);

    // R3
    m0_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_n[0] && req_n[0] && !req_n[1]) |=> (gnt_n == 2'b11));

    // R3
    m1_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_n[1] && req_n[1] && !req_n[0]) |=> (gnt_n == 2'b11));

    // R5
    m0_tenure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_n[0] && !req_n[0] && tenure_active) |=> !gnt_n[0]);

    // R5
    m1_tenure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!gnt_n[1] && !req_n[1] && tenure_active) |=> !gnt_n[1]);

    // R6
    tenure_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ts_n && btt_n && !bb_n) |=> tenure_active);

    // R7
    tenure_btt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !btt_n |=> !tenure_active);

    // R8
    tenure_bb_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bb_n) |=> !tenure_active);

    // R9
    parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_n == 2'b11 && gnt_n != 2'b11) |=> $stable(gnt_n));

    generate
        if (GAP_CYCLES == 1) begin : g_single_gap
            // R10
            gap_to_m1_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_n == 2'b11 && $past(!gnt_n[0])) |=> !gnt_n[1]);
            // R10
            gap_to_m0_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (gnt_n == 2'b11 && $past(!gnt_n[1])) |=> !gnt_n[0]);
        end
    endgenerate

endmodule

bind arb2_bus_arbiter arb2_bus_arbiter_chk #(
    .PARK_MASTER (PARK_MASTER),
    .GAP_CYCLES  (GAP_CYCLES)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_n         (req_n),
    .ts_n          (ts_n),
    .bb_n          (bb_n),
    .btt_n         (btt_n),
    .gnt_n         (gnt_n),
    .tenure_active (tenure_active)
);

// File: tb/arb2_bus_arbiter_tb_top.sv
module arb2_bus_arbiter_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] req_n = 2'b11;
    logic       ts_n = 1'b1;
    logic       bb_n = 1'b1;
    logic       btt_n = 1'b1;
    logic [1:0] gnt_n;
    logic       tenure_active;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    arb2_bus_arbiter dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_n         (req_n),
        .ts_n          (ts_n),
        .bb_n          (bb_n),
        .btt_n         (btt_n),
        .gnt_n         (gnt_n),
        .tenure_active (tenure_active)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_gnt(input logic [1:0] exp, input string tag);
        n_chk++;
        if (gnt_n !== exp) begin
            n_bad++;
            $display("FAIL %s: gnt_n actual %b expected %b", tag, gnt_n, exp);
        end
    endtask

    task automatic expect_ten(input logic exp, input string tag);
        n_chk++;
        if (tenure_active !== exp) begin
            n_bad++;
            $display("FAIL %s: tenure_active actual %b expected %b", tag, tenure_active, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic t_reset();
        step();
        step();
        expect_gnt(2'b10, "R1 park during reset");
        expect_ten(1'b0, "R1 tenure clear in reset");
        rst_n = 1'b1;
        step();
        expect_gnt(2'b10, "R1 park after release");
    endtask

    task automatic t_park();
        for (int i = 0; i < 4; i++) begin
            step();
            expect_gnt(2'b10, "R9 parked with no requests");
        end
    endtask

    task automatic t_handoff();
        req_n = 2'b01;
        step();
        expect_gnt(2'b11, "R3 grant removed (R2 gap)");
        step();
        expect_gnt(2'b01, "R3 grant to master 1");
        step();
        expect_gnt(2'b01, "R3 master 1 keeps grant");
        req_n = 2'b10;
        step();
        expect_gnt(2'b11, "R3 return gap");
        step();
        expect_gnt(2'b10, "R3 returned to master 0");
    endtask

    task automatic t_no_wait_alternate();
        req_n = 2'b00;
        step();
        expect_gnt(2'b11, "R4 owner requesting but idle loses grant");
        step();
        expect_gnt(2'b01, "R4 master 1 granted");
        step();
        expect_gnt(2'b11, "R11 alternation gap");
        step();
        expect_gnt(2'b10, "R11 back to master 0");
        step();
        expect_gnt(2'b11, "R11 second gap");
        step();
        expect_gnt(2'b01, "R11 again master 1");
        req_n = 2'b10;
        step();
        expect_gnt(2'b11, "R11 gap before master 0");
        step();
        expect_gnt(2'b10, "R11 master 0 granted");
    endtask

    task automatic t_tenure_hold();
        ts_n = 1'b0;
        step();
        expect_ten(1'b1, "R6 tenure set by ts_n");
        ts_n = 1'b1;
        req_n = 2'b00;
        step();
        expect_gnt(2'b10, "R5 hold during tenure");
        step();
        expect_gnt(2'b10, "R5 still held");
        expect_ten(1'b1, "R6 tenure persists");
        btt_n = 1'b0;
        step();
        expect_ten(1'b0, "R7 tenure cleared by btt_n");
        expect_gnt(2'b10, "R5 held at tenure end edge");
        btt_n = 1'b1;
        step();
        expect_gnt(2'b11, "R5 handover after tenure");
        step();
        expect_gnt(2'b01, "R5 master 1 granted");
        req_n = 2'b01;
    endtask

    task automatic t_tenure_edges();
        ts_n = 1'b0;
        bb_n = 1'b0;
        step();
        expect_ten(1'b1, "R6 set with bus busy low");
        ts_n = 1'b1;
        step();
        expect_ten(1'b1, "R8 no clear while bb_n low");
        bb_n = 1'b1;
        step();
        expect_ten(1'b0, "R8 cleared on bb_n rise");
        ts_n = 1'b0;
        btt_n = 1'b0;
        step();
        expect_ten(1'b0, "R7 btt_n wins over ts_n");
        btt_n = 1'b1;
        step();
        expect_ten(1'b1, "R6 set again");
        ts_n = 1'b1;
        btt_n = 1'b0;
        step();
        expect_ten(1'b0, "R7 cleared again");
        btt_n = 1'b1;
        expect_gnt(2'b01, "R5 master 1 kept grant through tenures");
    endtask

    task automatic t_gap_commit();
        req_n = 2'b10;
        step();
        expect_gnt(2'b11, "R10 gap started");
        req_n = 2'b11;
        step();
        expect_gnt(2'b10, "R10 gap completes after request dropped");
        step();
        expect_gnt(2'b10, "R9 parked on master 0");
    endtask

    initial begin
        t_reset();
        t_park();
        t_handoff();
        t_no_wait_alternate();
        t_tenure_hold();
        t_tenure_edges();
        t_gap_commit();
        done = 1'b1;
        report();
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            report();
        end
    end

endmodule